// File: doc/BRIEF.md
# Misaligned Access PC Predictor

This block keeps a short list of load and store instruction addresses that have already made a data access that was not naturally aligned. The translate stage presents the PC of each memory instruction it is about to expand. In the same cycle the block answers hit or miss. On a hit the translator emits the slow but safe expansion: several aligned accesses that together emulate the unaligned one. On a miss it emits the optimistic expansion, a single access that assumes natural alignment.

When an optimistic access turns out to be misaligned, the downstream soft-exception path drains the pipeline and sends the instruction back for retranslation. At that point it installs the faulting PC here, so the next dynamic instance of the same instruction is expanded safely from the start. The table is fully associative and every entry is compared against both the lookup PC and the install PC. Free slots are filled first. Once the table is full, entries are replaced in round-robin order. A flush input empties the table.

The install port has no back-pressure. It is a plain strobe that is accepted in every cycle, and an install request that must be dropped (non-memory, duplicate, or coinciding with a flush) is dropped silently.

Top module: `misalign_pc_predictor`

## Requirements
- R1: After reset deasserts, every lookup misses (`lookup_hit_o` = 0).
- R2: A lookup is combinational. When `lookup_is_mem_i` = 1 and `lookup_pc_i` equals a stored PC, `lookup_hit_o` is 1 in the same cycle. Otherwise it is 0.
- R3: When `lookup_is_mem_i` = 0, `lookup_hit_o` is 0 even if the PC is stored.
- R4: An install takes effect at the next rising clock edge. A lookup of the same PC in the install cycle still misses.
- R5: An install with `install_is_mem_i` = 0 is ignored and leaves the table unchanged.
- R6: Installing a PC that is already stored creates no second entry and consumes no replacement slot.
- R7: While empty slots remain, a new PC fills the lowest-index empty slot and nothing is evicted. Eight distinct installs all remain resident.
- R8: With all `ENTRIES` (8) slots valid, each new PC replaces slots in round-robin order. The order starts at slot 0, goes upward and wraps, so the first PC to be replaced is the first one that was installed.
- R9: `flush_i` = 1 at a clock edge invalidates all entries and returns the round-robin order to slot 0. A flush wins over an install in the same cycle.
- R10: Reset (`rst_n` = 0) has the same clearing effect as a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Invalidates the whole table at the next edge |
| lookup_pc_i | input | PC_W (32) | PC being translated |
| lookup_is_mem_i | input | 1 | The instruction at lookup_pc_i is a load or store |
| lookup_hit_o | output | 1 | 1: emit the safe multi-access expansion; 0: emit the single aligned access |
| install_valid_i | input | 1 | Install strobe from the retranslation path |
| install_is_mem_i | input | 1 | The installed instruction is a load or store |
| install_pc_i | input | PC_W (32) | PC that faulted on alignment |

## Verification
On every cycle, the embedded assertions check that no PC ever occupies two slots, that a non-memory lookup never hits, that a duplicate install leaves the valid set unchanged, that a fill grows the occupancy by exactly one, that eviction happens only when the table is full, and that a flush empties it. Only the directed scenarios can show which PC a replacement actually evicts: the round-robin order, its wrap, and its return to slot 0 after a flush. The same holds for the one-cycle delay between an install and its visible hit.

// File: rtl/upp_pkg.sv
package upp_pkg;
  typedef enum logic [1:0] {
    INS_NONE  = 2'd0,
    INS_DUP   = 2'd1,
    INS_FILL  = 2'd2,
    INS_EVICT = 2'd3
  } ins_act_e;
endpackage

// File: rtl/upp_cam.sv
module upp_cam #(
  parameter int ENTRIES = 8,
  parameter int PC_W    = 32,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [PC_W-1:0]    wr_pc_i,
  input  logic [PC_W-1:0]    look_pc_i,
  input  logic [PC_W-1:0]    chk_pc_i,
  output logic [ENTRIES-1:0] valid_o,
  output logic [ENTRIES-1:0] look_match_o,
  output logic [ENTRIES-1:0] chk_match_o
);
  logic [PC_W-1:0] slot_pc [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
        valid_o[g] <= 1'b0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
        valid_o[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en_i && !clr_i && wr_idx_i == IDX_W'(g)) begin
        slot_pc[g] <= wr_pc_i;
      end
    end

    assign look_match_o[g] = valid_o[g] && (slot_pc[g] == look_pc_i);
    assign chk_match_o[g]  = valid_o[g] && (slot_pc[g] == chk_pc_i);
  end

  // R6: a stored PC never sits in two slots
  p_unique_pc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(look_match_o));

  // R9: a clear leaves no valid slot behind
  p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (valid_o == '0));
endmodule

// File: rtl/upp_victim.sv
module upp_victim #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic               evict_i,
  output logic               full_o,
  output logic [IDX_W-1:0]   free_idx_o,
  output logic [IDX_W-1:0]   rr_idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  assign full_o = &valid_i;

  always_comb begin
    free_idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) free_idx_o = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      rr_idx_o <= '0;
    end else if (evict_i) begin
      rr_idx_o <= (rr_idx_o == LAST) ? '0 : rr_idx_o + 1'b1;
    end
  end

  // R8: replacement only happens once every slot is occupied
  p_evict_only_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evict_i |-> full_o);
endmodule

// File: rtl/misalign_pc_predictor.sv
module misalign_pc_predictor #(
  parameter int ENTRIES = 8,
  parameter int PC_W    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush_i,
  input  logic [PC_W-1:0] lookup_pc_i,
  input  logic            lookup_is_mem_i,
  output logic            lookup_hit_o,
  input  logic            install_valid_i,
  input  logic            install_is_mem_i,
  input  logic [PC_W-1:0] install_pc_i
);
  import upp_pkg::*;

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid;
  logic [ENTRIES-1:0] look_match;
  logic [ENTRIES-1:0] chk_match;
  logic               full;
  logic [IDX_W-1:0]   free_idx;
  logic [IDX_W-1:0]   rr_idx;
  logic [IDX_W-1:0]   wr_idx;
  logic               wr_en;
  ins_act_e           act;

  always_comb begin
    if (flush_i || !install_valid_i || !install_is_mem_i) act = INS_NONE;
    else if (|chk_match)                                  act = INS_DUP;
    else if (!full)                                       act = INS_FILL;
    else                                                  act = INS_EVICT;
  end

  assign wr_en  = (act == INS_FILL) || (act == INS_EVICT);
  assign wr_idx = (act == INS_EVICT) ? rr_idx : free_idx;

  upp_cam #(.ENTRIES(ENTRIES), .PC_W(PC_W), .IDX_W(IDX_W)) u_cam (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_i        (flush_i),
    .wr_en_i      (wr_en),
    .wr_idx_i     (wr_idx),
    .wr_pc_i      (install_pc_i),
    .look_pc_i    (lookup_pc_i),
    .chk_pc_i     (install_pc_i),
    .valid_o      (valid),
    .look_match_o (look_match),
    .chk_match_o  (chk_match)
  );

  upp_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (flush_i),
    .valid_i    (valid),
    .evict_i    (act == INS_EVICT),
    .full_o     (full),
    .free_idx_o (free_idx),
    .rr_idx_o   (rr_idx)
  );

  assign lookup_hit_o = lookup_is_mem_i && (|look_match);

  // R3: non-memory instructions always take the optimistic path
  p_nonmem_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_is_mem_i |-> !lookup_hit_o);

  // R6: a duplicate install changes no valid bit
  p_dup_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act == INS_DUP) |=> $stable(valid));

  // R7: a fill adds exactly one occupied slot
  p_fill_grows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (act == INS_FILL) |=> ($countones(valid) == $past($countones(valid)) + 1));

  // R5: an ignored install leaves the valid set unchanged
  p_nonmem_install_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (install_valid_i && !install_is_mem_i && !flush_i) |=> $stable(valid));
endmodule

// File: tb/misalign_pc_predictor_tb.sv
module misalign_pc_predictor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_i = 1'b0;
  logic [31:0] lookup_pc_i = '0;
  logic        lookup_is_mem_i = 1'b0;
  logic        lookup_hit_o;
  logic        install_valid_i = 1'b0;
  logic        install_is_mem_i = 1'b0;
  logic [31:0] install_pc_i = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  misalign_pc_predictor u_dut (
    .clk              (clk),
    .rst_n            (rst_n),
    .flush_i          (flush_i),
    .lookup_pc_i      (lookup_pc_i),
    .lookup_is_mem_i  (lookup_is_mem_i),
    .lookup_hit_o     (lookup_hit_o),
    .install_valid_i  (install_valid_i),
    .install_is_mem_i (install_is_mem_i),
    .install_pc_i     (install_pc_i)
  );

  function automatic logic [31:0] pa(int i); return 32'h0000_1000 + 32'(i) * 4; endfunction
  function automatic logic [31:0] pb(int i); return 32'h0000_8000 + 32'(i) * 4; endfunction

  task automatic look(input logic [31:0] pc, input logic mem, input logic exp, input string req);
    lookup_pc_i = pc;
    lookup_is_mem_i = mem;
    #1;
    n_chk++;
    if (lookup_hit_o !== exp) begin
      n_fail++;
      $display("FAIL %s pc=%h hit actual=%0b expected=%0b", req, pc, lookup_hit_o, exp);
    end
    lookup_is_mem_i = 1'b0;
  endtask

  task automatic install(input logic [31:0] pc, input logic mem);
    @(negedge clk);
    install_valid_i = 1'b1;
    install_is_mem_i = mem;
    install_pc_i = pc;
    @(negedge clk);
    install_valid_i = 1'b0;
    install_is_mem_i = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush_i = 1'b1;
    @(negedge clk);
    flush_i = 1'b0;
  endtask

  task automatic fill_a();
    for (int i = 0; i < 8; i++) install(pa(i), 1'b1);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 3; i++) look(pa(i), 1'b1, 1'b0, "R1");
  endtask

  task automatic t_fill();
    do_flush();
    fill_a();
    for (int i = 0; i < 8; i++) look(pa(i), 1'b1, 1'b1, "R7");
    look(pb(0), 1'b1, 1'b0, "R2");
    look(pa(3), 1'b0, 1'b0, "R3");
  endtask

  task automatic t_same_cycle();
    do_flush();
    @(negedge clk);
    install_valid_i = 1'b1;
    install_is_mem_i = 1'b1;
    install_pc_i = pb(5);
    look(pb(5), 1'b1, 1'b0, "R4");
    @(negedge clk);
    install_valid_i = 1'b0;
    install_is_mem_i = 1'b0;
    look(pb(5), 1'b1, 1'b1, "R4");
  endtask

  task automatic t_nonmem_install();
    do_flush();
    install(pb(1), 1'b0);
    look(pb(1), 1'b1, 1'b0, "R5");
  endtask

  task automatic t_dup();
    do_flush();
    fill_a();
    install(pa(0), 1'b1);
    install(pb(0), 1'b1);
    look(pa(0), 1'b1, 1'b0, "R6");
    look(pa(1), 1'b1, 1'b1, "R6");
    look(pb(0), 1'b1, 1'b1, "R6");
  endtask

  task automatic t_rr();
    do_flush();
    fill_a();
    for (int i = 0; i < 9; i++) install(pb(i), 1'b1);
    look(pb(0), 1'b1, 1'b0, "R8");
    look(pb(8), 1'b1, 1'b1, "R8");
    for (int i = 1; i < 8; i++) look(pb(i), 1'b1, 1'b1, "R8");
    for (int i = 0; i < 8; i++) look(pa(i), 1'b1, 1'b0, "R8");
  endtask

  task automatic t_flush();
    do_flush();
    fill_a();
    install(pb(0), 1'b1);
    install(pb(1), 1'b1);
    do_flush();
    look(pb(1), 1'b1, 1'b0, "R9");
    look(pa(5), 1'b1, 1'b0, "R9");
    @(negedge clk);
    flush_i = 1'b1;
    install_valid_i = 1'b1;
    install_is_mem_i = 1'b1;
    install_pc_i = pb(2);
    @(negedge clk);
    flush_i = 1'b0;
    install_valid_i = 1'b0;
    install_is_mem_i = 1'b0;
    look(pb(2), 1'b1, 1'b0, "R9");
    fill_a();
    install(pb(3), 1'b1);
    look(pa(0), 1'b1, 1'b0, "R9");
    look(pa(1), 1'b1, 1'b1, "R9");
  endtask

  task automatic t_reset_clear();
    fill_a();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    look(pa(2), 1'b1, 1'b0, "R10");
    fill_a();
    install(pb(4), 1'b1);
    look(pa(0), 1'b1, 1'b0, "R10");
    look(pa(7), 1'b1, 1'b1, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill();
    t_same_cycle();
    t_nonmem_install();
    t_dup();
    t_rr();
    t_flush();
    t_reset_clear();
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule